// File: doc/BRIEF.md
# RGMII Double-Data-Rate Receive Decoder with Transmit Encoder

This block sits between a reduced-pin gigabit PHY link and a byte-wide MAC datapath. On the receive side it samples a four-bit data bus and one control line on both edges of the receive clock. It rebuilds an eight-bit byte together with data-valid, receive-error and carrier-sense flags, and presents them on one rising-edge register stage in the receive clock domain. On the transmit side it takes a byte with enable and error flags and spreads them over four data lines and one control line, using both phases of the transmit clock.

At full rate (125 MHz clock) every clock carries one byte: the low nibble sits on the rising edge and the high nibble on the falling edge. At the lower rates (2.5 or 25 MHz clock) each clock carries one nibble. The receiver pairs consecutive nibbles, low nibble first, and flags each completed byte with a strobe. The transmitter expects each byte to be held for two clocks. In both directions the control line carries the valid or enable flag in one half of the clock and, in the other half, that flag XOR the error flag. A rising-half high with a falling-half low therefore marks an errored byte. A low rising half with a high falling half combined with an all-ones data byte marks a false carrier.

Top module: `rgmii_ddr_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `rx_dv`, `rx_er`, `rx_crs`, `rx_stb` low, and `rgmii_txd` = 0 with `rgmii_tx_ctl` low.
- R2: With `mode_gig` = 1, `rx_octet[3:0]` is the data sampled on a receive rising edge and `rx_octet[7:4]` is the data sampled on the falling edge that follows. Both appear after the next rising edge.
- R3: `rx_dv` equals the control value sampled on the rising edge, and `rx_er` equals the rising-edge control value XOR the falling-edge control value. Both are aligned with the byte they describe.
- R4: `rx_crs` is high exactly when `rx_dv` is high, or when `rx_dv` is low, `rx_er` is high and `rx_octet` is 8'hFF.
- R5: With `mode_gig` = 1, `rx_stb` is high on every cycle after reset.
- R6: With `mode_gig` = 1, `rgmii_txd` shows `tx_octet[3:0]` while `tx_clk` is high and `tx_octet[7:4]` while `tx_clk` is low. The byte is taken at the preceding `tx_clk` rising edge.
- R7: `rgmii_tx_ctl` shows `tx_en` while `tx_clk` is high and `tx_en` XOR `tx_er` while `tx_clk` is low. Both values are taken at the preceding rising edge.
- R8: With `mode_gig` = 0, only the rising-edge nibble is used. Two consecutive active nibbles form one byte, the first nibble giving bits 3:0. `rx_stb` pulses for one cycle per completed byte and is never high on two cycles in a row. The byte's valid flag is the AND of the two nibbles' valid flags, and its error flag is the OR of their error flags.
- R9: With `mode_gig` = 0, a nibble whose control is low on both edges clears `rx_dv`, `rx_er` and `rx_crs` and restarts pairing, so a lone half byte yields no byte.
- R10: With `mode_gig` = 0, the transmitter drives `tx_octet[3:0]` on both phases in the first clock of a byte and `tx_octet[7:4]` in the second clock. The nibble order restarts whenever `tx_en` and `tx_er` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock from the PHY |
| tx_clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset, used in both clock domains |
| mode_gig | input | 1 | 1: one byte per clock; 0: one nibble per clock |
| rgmii_rxd | input | 4 | Receive data, sampled on both edges |
| rgmii_rx_ctl | input | 1 | Receive control, sampled on both edges |
| rx_octet | output | 8 | Rebuilt receive byte |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rx_crs | output | 1 | Carrier sense |
| rx_stb | output | 1 | Byte outputs hold a newly completed byte |
| tx_octet | input | 8 | Byte to transmit |
| tx_en | input | 1 | Transmit enable |
| tx_er | input | 1 | Transmit error |
| rgmii_txd | output | 4 | Transmit data, changes with each clock phase |
| rgmii_tx_ctl | output | 1 | Transmit control, changes with each clock phase |

## Verification
On every clock, the assertions check several relations at full rate. They check the carrier-sense relation among the receive outputs, and the two-edge latency from the rising-edge control and low nibble to `rx_dv` and `rx_octet[3:0]`. They also check that the pin values seen in the transmit low phase match the high nibble and the enable XOR error of the byte latched one edge earlier, and that the strobe pattern follows the mode. The falling-edge nibble on the receive side, the nibble pairing at the lower rates, and the restart after a lone half byte are covered only by the bench's loopback scenarios. The same holds for the all-ones false-carrier and carrier-extension codes and for the exact pin values within each transmit clock phase.

// File: rtl/rgmii_ddr_pkg.sv
// Shared definitions for the RGMII DDR bridge.
// Assumes: a nibble lane of NIB_W_DEF bits; a byte is two nibbles.
package rgmii_ddr_pkg;
    localparam int NIB_W_DEF = 4;

    // Which half of a byte the nibble-rate datapath is working on.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } nib_phase_e;
endpackage

// File: rtl/rgmii_rx_capture.sv
// Edge capture for the receive pins.
// Samples data and control once on the rising edge and once on the falling
// edge of rx_clk. Both sets are held until the next rising edge, when the
// decoder consumes them together.
// Assumes: the PHY clock is skewed so that both edges land inside the data eye.
module rgmii_rx_capture #(
    parameter int NIB_W = rgmii_ddr_pkg::NIB_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] pin_d,
    input  logic             pin_ctl,
    output logic [NIB_W-1:0] rise_d,
    output logic             rise_ctl,
    output logic [NIB_W-1:0] fall_d,
    output logic             fall_ctl
);
    // Rising-edge sample: low nibble and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_d   <= '0;
            rise_ctl <= 1'b0;
        end else begin
            rise_d   <= pin_d;
            rise_ctl <= pin_ctl;
        end
    end

    // Falling-edge sample: high nibble and valid XOR error.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fall_d   <= '0;
            fall_ctl <= 1'b0;
        end else begin
            fall_d   <= pin_d;
            fall_ctl <= pin_ctl;
        end
    end
endmodule

// File: rtl/rgmii_rx_decode.sv
// Receive decoder: turns one rising/falling sample pair per clock into a
// byte with valid, error, carrier and strobe, all from one rising-edge stage.
// At full rate each clock yields a byte. At nibble rate only the rising
// sample is used and two active nibbles are paired, low nibble first.
// Assumes: mode_gig is static while traffic flows.
module rgmii_rx_decode
    import rgmii_ddr_pkg::*;
#(
    parameter int NIB_W = NIB_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_gig,
    input  logic [NIB_W-1:0]   rise_d,
    input  logic               rise_ctl,
    input  logic [NIB_W-1:0]   fall_d,
    input  logic               fall_ctl,
    output logic [2*NIB_W-1:0] octet_o,
    output logic               dv_o,
    output logic               er_o,
    output logic               crs_o,
    output logic               stb_o
);
    localparam int BYTE_W = 2 * NIB_W;

    nib_phase_e       phase_q;
    logic [NIB_W-1:0] lo_nib_q;
    logic             lo_dv_q;
    logic             lo_er_q;

    logic              nib_dv, nib_er, nib_active;
    logic [BYTE_W-1:0] gig_octet, pair_octet;
    logic              pair_dv, pair_er;

    // Per-clock control decode and candidate bytes for both rates.
    always_comb begin
        nib_dv     = rise_ctl;
        nib_er     = rise_ctl ^ fall_ctl;
        nib_active = rise_ctl | fall_ctl;
        gig_octet  = {fall_d, rise_d};
        pair_octet = {rise_d, lo_nib_q};
        pair_dv    = lo_dv_q & nib_dv;
        pair_er    = lo_er_q | nib_er;
    end

    // Output stage and nibble pairing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            octet_o  <= '0;
            dv_o     <= 1'b0;
            er_o     <= 1'b0;
            crs_o    <= 1'b0;
            stb_o    <= 1'b0;
            phase_q  <= PH_LOW;
            lo_nib_q <= '0;
            lo_dv_q  <= 1'b0;
            lo_er_q  <= 1'b0;
        end else if (mode_gig) begin
            octet_o <= gig_octet;
            dv_o    <= nib_dv;
            er_o    <= nib_er;
            crs_o   <= nib_dv | (nib_er & (&gig_octet));
            stb_o   <= 1'b1;
            phase_q <= PH_LOW;
        end else if (!nib_active) begin
            dv_o    <= 1'b0;
            er_o    <= 1'b0;
            crs_o   <= 1'b0;
            stb_o   <= 1'b0;
            phase_q <= PH_LOW;
        end else if (phase_q == PH_LOW) begin
            lo_nib_q <= rise_d;
            lo_dv_q  <= nib_dv;
            lo_er_q  <= nib_er;
            stb_o    <= 1'b0;
            phase_q  <= PH_HIGH;
        end else begin
            octet_o <= pair_octet;
            dv_o    <= pair_dv;
            er_o    <= pair_er;
            crs_o   <= pair_dv | (pair_er & (&pair_octet));
            stb_o   <= 1'b1;
            phase_q <= PH_LOW;
        end
    end
endmodule

// File: rtl/rgmii_tx_encode.sv
// Transmit encoder: latches a byte plus enable/error on the rising edge of
// tx_clk and drives one nibble and one control value per clock phase.
// High phase: low nibble and enable. Low phase: high nibble and
// enable XOR error. At nibble rate both phases repeat one nibble, low first.
// Assumes: at nibble rate the caller holds each byte for two clocks.
module rgmii_tx_encode
    import rgmii_ddr_pkg::*;
#(
    parameter int NIB_W = NIB_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_gig,
    input  logic [2*NIB_W-1:0] octet_i,
    input  logic               en_i,
    input  logic               er_i,
    output logic [NIB_W-1:0]   txd_o,
    output logic               ctl_o
);
    localparam int BYTE_W = 2 * NIB_W;

    nib_phase_e       phase_q;
    logic [NIB_W-1:0] hi_phase_q, lo_phase_q;
    logic             ctl_hi_q, ctl_lo_q;
    logic [NIB_W-1:0] nib_sel;

    // Nibble chosen for the current clock at nibble rate.
    always_comb begin
        nib_sel = (phase_q == PH_HIGH) ? octet_i[BYTE_W-1:NIB_W] : octet_i[NIB_W-1:0];
    end

    // Latch both clock-phase values on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_phase_q <= '0;
            lo_phase_q <= '0;
            ctl_hi_q   <= 1'b0;
            ctl_lo_q   <= 1'b0;
            phase_q    <= PH_LOW;
        end else begin
            ctl_hi_q <= en_i;
            ctl_lo_q <= en_i ^ er_i;
            if (mode_gig) begin
                hi_phase_q <= octet_i[NIB_W-1:0];
                lo_phase_q <= octet_i[BYTE_W-1:NIB_W];
                phase_q    <= PH_LOW;
            end else begin
                hi_phase_q <= nib_sel;
                lo_phase_q <= nib_sel;
                if (en_i | er_i)
                    phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
                else
                    phase_q <= PH_LOW;
            end
        end
    end

    // Clock-phase output select: the double-data-rate pin driver.
    always_comb begin
        txd_o = clk ? hi_phase_q : lo_phase_q;
        ctl_o = clk ? ctl_hi_q : ctl_lo_q;
    end
endmodule

// File: rtl/rgmii_ddr_bridge.sv
// Top of the RGMII DDR bridge: receive capture plus decode in the rx_clk
// domain, transmit encode in the tx_clk domain. The two directions share
// only the reset and the rate select.
// Assumes: rst_n is held long enough to span clock edges in both domains.
module rgmii_ddr_bridge #(
    parameter int NIB_W  = rgmii_ddr_pkg::NIB_W_DEF,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              rx_clk,
    input  logic              tx_clk,
    input  logic              rst_n,
    input  logic              mode_gig,
    input  logic [NIB_W-1:0]  rgmii_rxd,
    input  logic              rgmii_rx_ctl,
    output logic [BYTE_W-1:0] rx_octet,
    output logic              rx_dv,
    output logic              rx_er,
    output logic              rx_crs,
    output logic              rx_stb,
    input  logic [BYTE_W-1:0] tx_octet,
    input  logic              tx_en,
    input  logic              tx_er,
    output logic [NIB_W-1:0]  rgmii_txd,
    output logic              rgmii_tx_ctl
);
    logic [NIB_W-1:0] cap_rise_d, cap_fall_d;
    logic             cap_rise_ctl, cap_fall_ctl;

    rgmii_rx_capture #(.NIB_W(NIB_W)) u_rx_cap (
        .clk      (rx_clk),
        .rst_n    (rst_n),
        .pin_d    (rgmii_rxd),
        .pin_ctl  (rgmii_rx_ctl),
        .rise_d   (cap_rise_d),
        .rise_ctl (cap_rise_ctl),
        .fall_d   (cap_fall_d),
        .fall_ctl (cap_fall_ctl)
    );

    rgmii_rx_decode #(.NIB_W(NIB_W)) u_rx_dec (
        .clk      (rx_clk),
        .rst_n    (rst_n),
        .mode_gig (mode_gig),
        .rise_d   (cap_rise_d),
        .rise_ctl (cap_rise_ctl),
        .fall_d   (cap_fall_d),
        .fall_ctl (cap_fall_ctl),
        .octet_o  (rx_octet),
        .dv_o     (rx_dv),
        .er_o     (rx_er),
        .crs_o    (rx_crs),
        .stb_o    (rx_stb)
    );

    rgmii_tx_encode #(.NIB_W(NIB_W)) u_tx_enc (
        .clk      (tx_clk),
        .rst_n    (rst_n),
        .mode_gig (mode_gig),
        .octet_i  (tx_octet),
        .en_i     (tx_en),
        .er_i     (tx_er),
        .txd_o    (rgmii_txd),
        .ctl_o    (rgmii_tx_ctl)
    );
endmodule

// File: rtl/rgmii_ddr_bridge_chk.sv
// Property checker for rgmii_ddr_bridge, attached through bind.
// Observes only top-level ports. Receive properties use rx_clk and transmit
// properties use tx_clk.
module rgmii_ddr_bridge_chk #(
    parameter int NIB_W  = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input logic              rx_clk,
    input logic              tx_clk,
    input logic              rst_n,
    input logic              mode_gig,
    input logic [NIB_W-1:0]  rgmii_rxd,
    input logic              rgmii_rx_ctl,
    input logic [BYTE_W-1:0] rx_octet,
    input logic              rx_dv,
    input logic              rx_er,
    input logic              rx_crs,
    input logic              rx_stb,
    input logic [BYTE_W-1:0] tx_octet,
    input logic              tx_en,
    input logic              tx_er,
    input logic [NIB_W-1:0]  rgmii_txd,
    input logic              rgmii_tx_ctl
);
    p_rx_reset_r1: assert property (@(posedge rx_clk)
        !rst_n |=> (!rx_dv && !rx_er && !rx_crs && !rx_stb));

    p_tx_reset_r1: assert property (@(posedge tx_clk)
        !rst_n |=> (rgmii_txd == '0 && !rgmii_tx_ctl));

    p_low_nibble_r2: assert property (@(posedge rx_clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && mode_gig && $past(mode_gig) && $past(mode_gig, 2))
        |-> rx_octet[NIB_W-1:0] == $past(rgmii_rxd, 2));

    p_valid_r3: assert property (@(posedge rx_clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && mode_gig && $past(mode_gig) && $past(mode_gig, 2))
        |-> rx_dv == $past(rgmii_rx_ctl, 2));

    p_carrier_r4: assert property (@(posedge rx_clk) disable iff (!rst_n)
        rx_crs == (rx_dv || (rx_er && (&rx_octet))));

    p_gig_strobe_r5: assert property (@(posedge rx_clk) disable iff (!rst_n)
        ($past(rst_n) && mode_gig && $past(mode_gig)) |-> rx_stb);

    p_tx_hi_nibble_r6: assert property (@(posedge tx_clk) disable iff (!rst_n)
        ($past(rst_n) && mode_gig && $past(mode_gig))
        |-> rgmii_txd == $past(tx_octet[BYTE_W-1:NIB_W]));

    p_tx_ctl_low_r7: assert property (@(posedge tx_clk) disable iff (!rst_n)
        $past(rst_n) |-> rgmii_tx_ctl == $past(tx_en ^ tx_er));

    p_slow_strobe_r8: assert property (@(posedge rx_clk) disable iff (!rst_n)
        (!mode_gig && $past(!mode_gig) && rx_stb) |=> (mode_gig || !rx_stb));
endmodule

bind rgmii_ddr_bridge rgmii_ddr_bridge_chk #(.NIB_W(NIB_W)) u_chk (
    .rx_clk       (rx_clk),
    .tx_clk       (tx_clk),
    .rst_n        (rst_n),
    .mode_gig     (mode_gig),
    .rgmii_rxd    (rgmii_rxd),
    .rgmii_rx_ctl (rgmii_rx_ctl),
    .rx_octet     (rx_octet),
    .rx_dv        (rx_dv),
    .rx_er        (rx_er),
    .rx_crs       (rx_crs),
    .rx_stb       (rx_stb),
    .tx_octet     (tx_octet),
    .tx_en        (tx_en),
    .tx_er        (tx_er),
    .rgmii_txd    (rgmii_txd),
    .rgmii_tx_ctl (rgmii_tx_ctl)
);

// File: tb/rgmii_ddr_bridge_tb.sv
`timescale 1ns/1ps
// Loopback bench: transmit pins feed receive pins. rx_clk lags tx_clk by a
// quarter period, so both receive edges sample inside a stable phase.
module rgmii_ddr_bridge_tb;
    logic       tx_clk = 1'b0;
    logic       rx_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_gig = 1'b1;
    logic [7:0] tx_octet = 8'h00;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd;
    logic       txctl;
    logic [7:0] rx_octet;
    logic       rx_dv, rx_er, rx_crs, rx_stb;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] q_oct[$];
    logic       q_dv[$];
    logic       q_er[$];
    logic       q_crs[$];

    always #2.5 tx_clk = ~tx_clk;
    always @(tx_clk) rx_clk <= #1.25 tx_clk;

    rgmii_ddr_bridge u_dut (
        .rx_clk       (rx_clk),
        .tx_clk       (tx_clk),
        .rst_n        (rst_n),
        .mode_gig     (mode_gig),
        .rgmii_rxd    (txd),
        .rgmii_rx_ctl (txctl),
        .rx_octet     (rx_octet),
        .rx_dv        (rx_dv),
        .rx_er        (rx_er),
        .rx_crs       (rx_crs),
        .rx_stb       (rx_stb),
        .tx_octet     (tx_octet),
        .tx_en        (tx_en),
        .tx_er        (tx_er),
        .rgmii_txd    (txd),
        .rgmii_tx_ctl (txctl)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // One clock of stimulus; records completed receive bytes.
    task automatic step(input logic [7:0] b, input logic en, input logic er);
        @(negedge tx_clk);
        tx_octet = b;
        tx_en    = en;
        tx_er    = er;
        #1.25;
        if (rx_stb && (rx_dv || rx_er)) begin
            q_oct.push_back(rx_octet);
            q_dv.push_back(rx_dv);
            q_er.push_back(rx_er);
            q_crs.push_back(rx_crs);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(8'h00, 1'b0, 1'b0);
    endtask

    task automatic clear_rec();
        q_oct.delete(); q_dv.delete(); q_er.delete(); q_crs.delete();
    endtask

    task automatic expect_rec(input int idx, input logic [7:0] oct, input logic dv,
                              input logic er, input logic crs, input string req);
        if (idx < q_oct.size())
            check({q_oct[idx], q_dv[idx], q_er[idx], q_crs[idx]} == {oct, dv, er, crs},
                  req, $sformatf("record %0d {octet,dv,er,crs}", idx),
                  int'({q_oct[idx], q_dv[idx], q_er[idx], q_crs[idx]}),
                  int'({oct, dv, er, crs}));
        else
            check(1'b0, req, $sformatf("record %0d missing", idx), 'hfff, int'({oct, dv, er, crs}));
    endtask

    // R1: outputs while reset is held
    task automatic test_reset();
        repeat (4) @(negedge tx_clk);
        #1.25;
        check(!rx_dv && !rx_er && !rx_crs && !rx_stb, "R1", "rx flags in reset",
              int'({rx_dv, rx_er, rx_crs, rx_stb}), 0);
        @(posedge tx_clk); #1;
        check(txd == 4'h0 && !txctl, "R1", "tx pins in reset high phase", int'({txd, txctl}), 0);
        @(negedge tx_clk); #1;
        check(txd == 4'h0 && !txctl, "R1", "tx pins in reset low phase", int'({txd, txctl}), 0);
        @(negedge tx_clk);
        rst_n = 1'b1;
        idle(3);
    endtask

    // R6, R7: pin values within each transmit clock phase
    task automatic tx_probe(input logic [7:0] b, input logic en, input logic er);
        step(b, en, er);
        @(posedge tx_clk); #1;
        check(txd == b[3:0], "R6", "txd high phase", txd, b[3:0]);
        check(txctl == en, "R7", "ctl high phase", txctl, en);
        @(negedge tx_clk); #1;
        check(txd == b[7:4], "R6", "txd low phase", txd, b[7:4]);
        check(txctl == (en ^ er), "R7", "ctl low phase", txctl, en ^ er);
    endtask

    task automatic test_tx_pins();
        tx_probe(8'hA5, 1'b1, 1'b0);
        tx_probe(8'h3C, 1'b1, 1'b1);
        tx_probe(8'hFF, 1'b0, 1'b1);
        idle(3);
    endtask

    // R2, R3, R5: full-rate frame, one byte per clock
    task automatic test_gig_frame();
        logic [7:0] data [8] = '{8'h55, 8'hD5, 8'h00, 8'hFF, 8'h12, 8'h80, 8'h7E, 8'hC3};
        logic       errs [8] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
        clear_rec();
        for (int i = 0; i < 8; i++) step(data[i], 1'b1, errs[i]);
        idle(4);
        check(q_oct.size() == 8, "R2", "full-rate record count", q_oct.size(), 8);
        for (int i = 0; i < 8; i++) expect_rec(i, data[i], 1'b1, errs[i], 1'b1, "R2 R3");
        check(rx_stb == 1'b1, "R5", "strobe during idle at full rate", rx_stb, 1);
        check(!rx_dv && !rx_crs, "R3", "idle decode", int'({rx_dv, rx_crs}), 0);
    endtask

    // R4: false carrier versus carrier extension at full rate
    task automatic test_false_carrier();
        clear_rec();
        step(8'hFF, 1'b0, 1'b1);
        step(8'h0F, 1'b0, 1'b1);
        idle(4);
        check(q_oct.size() == 2, "R4", "special code count", q_oct.size(), 2);
        expect_rec(0, 8'hFF, 1'b0, 1'b1, 1'b1, "R4");
        expect_rec(1, 8'h0F, 1'b0, 1'b1, 1'b0, "R4");
        check(!rx_crs, "R4", "carrier after idle", rx_crs, 0);
    endtask

    // R8, R10: nibble-rate frame, each byte held two clocks
    task automatic test_slow_frame();
        logic [7:0] data [4] = '{8'h5D, 8'hA3, 8'hFF, 8'h3C};
        logic       errs [4] = '{1'b0, 1'b0, 1'b0, 1'b1};
        @(negedge tx_clk);
        mode_gig = 1'b0;
        idle(3);
        clear_rec();
        for (int i = 0; i < 4; i++) begin
            step(data[i], 1'b1, errs[i]);
            step(data[i], 1'b1, errs[i]);
        end
        idle(5);
        check(q_oct.size() == 4, "R8", "nibble-rate record count", q_oct.size(), 4);
        for (int i = 0; i < 4; i++) expect_rec(i, data[i], 1'b1, errs[i], 1'b1, "R8 R10");
        check(!rx_stb, "R8", "no strobe when idle", rx_stb, 0);
    endtask

    // R9: lone half byte is dropped and pairing restarts
    task automatic test_slow_restart();
        clear_rec();
        step(8'h96, 1'b1, 1'b0);
        idle(4);
        check(q_oct.size() == 0, "R9", "half byte yields nothing", q_oct.size(), 0);
        check(!rx_dv && !rx_er && !rx_crs, "R9", "flags cleared", int'({rx_dv, rx_er, rx_crs}), 0);
        step(8'h4B, 1'b1, 1'b0);
        step(8'h4B, 1'b1, 1'b0);
        idle(5);
        check(q_oct.size() == 1, "R9", "byte after restart count", q_oct.size(), 1);
        expect_rec(0, 8'h4B, 1'b1, 1'b0, 1'b1, "R9 R10");
    endtask

    // R4, R8: false carrier at nibble rate
    task automatic test_slow_false_carrier();
        clear_rec();
        step(8'hFF, 1'b0, 1'b1);
        step(8'hFF, 1'b0, 1'b1);
        idle(5);
        check(q_oct.size() == 1, "R4", "nibble-rate special count", q_oct.size(), 1);
        expect_rec(0, 8'hFF, 1'b0, 1'b1, 1'b1, "R4 R8");
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        test_reset();
        test_tx_pins();
        test_gig_frame();
        test_false_carrier();
        test_slow_frame();
        test_slow_restart();
        test_slow_false_carrier();
        finish_run();
    end
endmodule